// File: doc/BRIEF.md
# Split-Access 64-bit Register Bridge

This block is a register slave on a 32-bit bus. Behind it sit 64-bit registers, and software reaches each one as two 32-bit words. The first is a control register. Its low word holds a self-clearing software-reset bit. The other seven are 64-bit event counters. Three count request pulses and four accumulate byte counts. The address map is fixed:

- Register n sits at byte offset 8·n.
- Address bits [1:0] are ignored.
- The word at +0 carries bits 63:32 and the word at +4 carries bits 31:0.

Writing a 64-bit value takes two steps. Software first writes the upper word, which only stages it. It then writes the lower word, which commits the staged upper half and the new lower half together. Reads are also split but stay coherent. Reading the upper word captures the lower half of the same register into a shadow. The next lower-word read of that register returns the shadow. A counter that keeps running between the two accesses therefore cannot return a torn value. Read data is registered and appears on `bus_rdata` one clock after the read strobe.

Top module: `split64_reg_bridge`

## Requirements
- R1: After the asynchronous active-low reset, every register reads as zero and `sw_rst_o` is low.
- R2: A write to the control upper word (byte address 0x00) only stages the data, and the control register is unchanged. A write to the control lower word (0x04) commits {staged, written} as one 64-bit value.
- R3: A lower-word control write with no preceding upper-word write still commits, using the currently staged upper half. A staged value of zero is valid.
- R4: The counter words (indices 1 to 7, byte addresses 0x08 to 0x3F) are read-only. Writes to them leave every counter unchanged.
- R5: Request counters add 1 in each cycle their pulse input is high:
  - index 1 counts `ev_deq`,
  - index 2 counts `ev_enc_req`,
  - index 3 counts `ev_dec_req`.
- R6: Byte counters add their BYTE_W-bit count in each cycle its valid is high, and add nothing when it is low:
  - index 4 is encrypted bytes,
  - index 5 is protected bytes,
  - index 6 is decrypted bytes,
  - index 7 is validated bytes.
- R7: Counters are full 64-bit and wrap modulo 2^64. A carry out of bit 31 reaches the upper word.
- R8: An upper-word read of register n captures bits 31:0 of that register at the same cycle. The next lower-word read of register n returns the captured value, even if the register has changed in between.
- R9: A lower-word read with no pending capture for that same register returns the live bits 31:0. A capture is consumed by one lower-word read.
- R10: Writing bit 31 = 1 to the control lower word has these effects:
  - `sw_rst_o` goes high for exactly the following cycle;
  - bit 31 is not stored;
  - all counters, the staged upper half and any pending capture are cleared;
  - the other committed control bits are kept.
- R11: Reads of register indices above 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| ev_deq | input | 1 | Request-dequeued pulse |
| ev_enc_req | input | 1 | Encrypt-request pulse |
| ev_dec_req | input | 1 | Decrypt-request pulse |
| enc_bytes_vld | input | 1 | Encrypted byte count valid |
| enc_bytes | input | BYTE_W | Encrypted byte count |
| prot_bytes_vld | input | 1 | Protected byte count valid |
| prot_bytes | input | BYTE_W | Protected byte count |
| dec_bytes_vld | input | 1 | Decrypted byte count valid |
| dec_bytes | input | BYTE_W | Decrypted byte count |
| val_bytes_vld | input | 1 | Validated byte count valid |
| val_bytes | input | BYTE_W | Validated byte count |
| sw_rst_o | output | 1 | Single-cycle software reset pulse |

## Verification
The bench uses the defaults ADDR_W = 8 and BYTE_W = 16. With 16-bit counts of 0xFFFF, a carry out of the lower word takes 65,538 cycles. That makes a real crossing into the upper word reachable in one run, and the coherent-read check is then made across that boundary. Wrap at 2^64 is not reachable in the cycle budget and rests on the 64-bit adder alone. Staging, commit, reset-pulse and shadow interleavings are driven in several orders: upper then lower, lower alone, and an upper read of one register followed by a lower read of another.

// File: rtl/split64_reg_bridge.sv
module split64_reg_bridge #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_deq,
  input  logic              ev_enc_req,
  input  logic              ev_dec_req,
  input  logic              enc_bytes_vld,
  input  logic [BYTE_W-1:0] enc_bytes,
  input  logic              prot_bytes_vld,
  input  logic [BYTE_W-1:0] prot_bytes,
  input  logic              dec_bytes_vld,
  input  logic [BYTE_W-1:0] dec_bytes,
  input  logic              val_bytes_vld,
  input  logic [BYTE_W-1:0] val_bytes,
  output logic              sw_rst_o
);
  localparam int NUM_CNT = 7;
  localparam int IDX_W   = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             upper;
  assign idx   = bus_addr[ADDR_W-1:3];
  assign upper = ~bus_addr[2];

  logic [63:0]      ctrl_q;
  logic [31:0]      stage_q, shadow_q;
  logic             shadow_vld;
  logic [IDX_W-1:0] shadow_idx;
  logic [63:0]      cnt_q [NUM_CNT];
  logic [63:0]      inc   [NUM_CNT];
  logic [63:0]      live;

  wire wr_ctrl_hi = bus_wr && (idx == '0) && upper;
  wire wr_ctrl_lo = bus_wr && (idx == '0) && !upper;

  assign inc[0] = 64'(ev_deq);
  assign inc[1] = 64'(ev_enc_req);
  assign inc[2] = 64'(ev_dec_req);
  assign inc[3] = enc_bytes_vld  ? 64'(enc_bytes)  : '0;
  assign inc[4] = prot_bytes_vld ? 64'(prot_bytes) : '0;
  assign inc[5] = dec_bytes_vld  ? 64'(dec_bytes)  : '0;
  assign inc[6] = val_bytes_vld  ? 64'(val_bytes)  : '0;

  always_comb begin
    live = (idx == '0) ? ctrl_q : '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (idx == IDX_W'(i + 1)) live = cnt_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      stage_q  <= '0;
      sw_rst_o <= 1'b0;
    end else begin
      sw_rst_o <= wr_ctrl_lo && bus_wdata[31];
      if (sw_rst_o)        stage_q <= '0;
      else if (wr_ctrl_hi) stage_q <= bus_wdata;
      if (wr_ctrl_lo)      ctrl_q  <= {stage_q, bus_wdata & 32'h7FFF_FFFF};
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q[g] <= '0;
      else if (sw_rst_o) cnt_q[g] <= '0;
      else               cnt_q[g] <= cnt_q[g] + inc[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      shadow_q   <= '0;
      shadow_vld <= 1'b0;
      shadow_idx <= '0;
    end else begin
      if (bus_rd) begin
        if (upper) begin
          bus_rdata  <= live[63:32];
          shadow_q   <= live[31:0];
          shadow_vld <= 1'b1;
          shadow_idx <= idx;
        end else begin
          bus_rdata  <= (shadow_vld && shadow_idx == idx) ? shadow_q : live[31:0];
          shadow_vld <= 1'b0;
        end
      end
      if (sw_rst_o) shadow_vld <= 1'b0;
    end
  end
endmodule

module split64_reg_bridge_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              sw_rst_o,
  input logic              ev_deq,
  input logic [63:0]       ctrl_q,
  input logic [63:0]       deq_q
);
  wire ctrl_hi_wr = bus_wr && bus_addr[ADDR_W-1:2] == '0;
  wire ctrl_lo_wr = bus_wr && bus_addr[ADDR_W-1:3] == '0 && bus_addr[2];

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_o |=> !sw_rst_o); // R10
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_lo_wr && bus_wdata[31]) |=> sw_rst_o); // R10
  AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_o |=> deq_q == 64'd0); // R10
  AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hi_wr |=> $stable(ctrl_q)); // R2
  AST_DEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst_o |=> deq_q == $past(deq_q) + 64'($past(ev_deq))); // R5
endmodule

bind split64_reg_bridge split64_reg_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sw_rst_o(sw_rst_o), .ev_deq(ev_deq),
  .ctrl_q(ctrl_q), .deq_q(cnt_q[0])
);

// File: tb/tb_split64_reg_bridge.sv
module tb_split64_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_deq = 0, ev_enc_req = 0, ev_dec_req = 0;
  logic        enc_bytes_vld = 0, prot_bytes_vld = 0, dec_bytes_vld = 0, val_bytes_vld = 0;
  logic [15:0] enc_bytes = 0, prot_bytes = 0, dec_bytes = 0, val_bytes = 0;
  logic        sw_rst_o;

  always #5 clk = ~clk;

  split64_reg_bridge dut (.*);

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;
  logic [63:0] m [7];
  logic [63:0] snap;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] e);
    tests++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got=%h expected=%h", t, act, e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rd64(input int n, input logic [63:0] e, input string t);
    rd(8'(n * 8), e[63:32], t);
    rd(8'(n * 8 + 4), e[31:0], t);
  endtask

  task automatic run(input int n, input logic d, input logic er, input logic dr,
                     input logic ve, input logic [15:0] be, input logic vp, input logic [15:0] bp,
                     input logic vd, input logic [15:0] bd, input logic vv, input logic [15:0] bv);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ev_deq = d; ev_enc_req = er; ev_dec_req = dr;
      enc_bytes_vld = ve; enc_bytes = be; prot_bytes_vld = vp; prot_bytes = bp;
      dec_bytes_vld = vd; dec_bytes = bd; val_bytes_vld = vv; val_bytes = bv;
      m[0] += 64'(d); m[1] += 64'(er); m[2] += 64'(dr);
      if (ve) m[3] += 64'(be);
      if (vp) m[4] += 64'(bp);
      if (vd) m[5] += 64'(bd);
      if (vv) m[6] += 64'(bv);
    end
    @(negedge clk);
    {ev_deq, ev_enc_req, ev_dec_req} = '0;
    {enc_bytes_vld, prot_bytes_vld, dec_bytes_vld, val_bytes_vld} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 sw_rst_o after reset", 32'(sw_rst_o), 0);
    rd64(0, 64'd0, "R1 control after reset");
    for (int i = 1; i <= 7; i++) rd64(i, 64'd0, "R1 counter after reset");

    wr(8'h00, 32'hAAAA_5555);
    rd(8'h00, 32'h0, "R2 staged upper not visible");
    wr(8'h04, 32'h0000_1234);
    rd64(0, 64'hAAAA5555_00001234, "R2 commit upper+lower");

    wr(8'h04, 32'h0000_0077);
    rd64(0, 64'hAAAA5555_00000077, "R3 lower alone uses staged");
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0000_0007);
    rd64(0, 64'h00000000_00000007, "R3 staged zero commits");

    run(5, 1, 1, 0, 1, 16'd100, 0, 16'h55, 1, 16'd7, 0, 16'd0);
    run(3, 0, 1, 1, 0, 16'h33, 1, 16'd9, 1, 16'd1, 1, 16'hFFFF);
    rd64(1, m[0], "R5 dequeued count");
    rd64(2, m[1], "R5 encrypt request count");
    rd64(3, m[2], "R5 decrypt request count");
    rd64(4, m[3], "R6 encrypted bytes");
    rd64(5, m[4], "R6 protected bytes");
    rd64(6, m[5], "R6 decrypted bytes");
    rd64(7, m[6], "R6 validated bytes");

    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h38, 32'h1234_5678);
    rd64(1, m[0], "R4 write to counter ignored");
    rd64(7, m[6], "R4 write to counter ignored");
    rd64(0, 64'h00000000_00000007, "R4 control untouched by counter writes");

    m[4] = '0;
    wr(8'h04, 32'h8000_0007);
    check("R10 pulse high after write", 32'(sw_rst_o), 1);
    @(negedge clk);
    check("R10 pulse single cycle", 32'(sw_rst_o), 0);
    for (int i = 0; i < 7; i++) m[i] = '0;
    rd64(5, 64'd0, "R10 counter cleared");
    rd64(1, 64'd0, "R10 counter cleared");

    run(65538, 0, 0, 0, 0, 0, 1, 16'hFFFF, 0, 0, 0, 0);
    check("R7 model carry", m[4][31:0], 32'h0000_FFFE);
    rd64(5, m[4], "R7 carry into upper word");

    snap = m[4];
    rd(8'h28, snap[63:32], "R8 upper read");
    run(3, 1, 0, 0, 0, 0, 1, 16'h0010, 0, 0, 0, 0);
    rd(8'h2C, snap[31:0], "R8 lower returns captured half");
    rd(8'h2C, m[4][31:0], "R9 second lower read is live");
    rd(8'h28, m[4][63:32], "R8 upper read again");
    rd(8'h0C, m[0][31:0], "R9 lower of other register is live");
    rd(8'h2C, m[4][31:0], "R9 capture consumed by other lower read");

    rd64(8, 64'd0, "R11 index 8 reads zero");
    rd64(31, 64'd0, "R11 index 31 reads zero");

    wr(8'h00, 32'h1234_5678);
    rd(8'h00, 32'h0000_0000, "R10 ctrl before reset");
    wr(8'h04, 32'h8000_0003);
    check("R10 pulse from second reset", 32'(sw_rst_o), 1);
    for (int i = 0; i < 7; i++) m[i] = '0;
    @(negedge clk);
    rd64(0, 64'h12345678_00000003, "R10 bit31 not stored");
    rd64(5, 64'd0, "R10 counters cleared again");
    wr(8'h04, 32'h0000_0009);
    rd64(0, 64'h00000000_00000009, "R10 staging cleared");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule